// File: doc/BRIEF.md
# Two-Stage Buffered Input Capture Channel

This block timestamps transitions on one asynchronous input pin against a free-running counter supplied from outside. A selectable edge detector picks rising, falling or both transitions. In buffered mode every qualified transition shifts the older timestamp from the capture register into a holding register behind it, and loads the newest counter value into the capture register. Software therefore always sees the two most recent event times. The first transition after the channel is armed only primes the capture register. From the second transition onward the interrupt flag is raised.

An optional no-overwrite protection freezes both registers once they have been filled. They stay frozen until software has read both of them, so a burst of pin activity cannot replace timestamps that nobody has collected. The two reads and the flag clear may come in any order. Pin activity during that service window is dropped without wedging the channel, so later transitions still raise the flag. With buffering off, the channel behaves as a plain single-register capture.

Top module: `icap_buffered_chan`

## Requirements
- R1: Edge select encoding: 2'b01 captures rising pin transitions, 2'b10 falling ones and 2'b11 both. A transition of the other polarity leaves the registers and the flag unchanged.
- R2: Edge select 2'b00 turns the channel off. Pin transitions then change nothing, and both registers are marked empty, so the first qualified transition after a nonzero select is written behaves as a first edge.
- R3: In buffered mode (buffer enable high), a qualified transition that finds both registers empty loads the counter into the capture register and leaves the holding register and the flag unchanged.
- R4: In buffered mode, a qualified transition that finds either register full copies the capture register into the holding register, loads the counter into the capture register and sets the flag.
- R5: With buffered mode and no-overwrite both on, once a shift has filled both registers, further transitions change neither register until both have been read. A single read does not release the freeze.
- R6: The service sequence (two register reads, one flag clear, in any order) may be interleaved with pin transitions. Once both reads are done, the channel captures again and raises the flag on the second later transition.
- R7: A one-cycle pulse on flag_clr clears the flag. When a flag-setting capture falls in the same cycle, the flag ends up set.
- R8: A pulse on rd_cap marks the capture register empty and a pulse on rd_hold marks the holding register empty, without changing their visible values. With both empty, the next transition acts as a first edge (R3).
- R9: With buffer enable low, every qualified transition loads the counter into the capture register and sets the flag, and the holding register is left unchanged. If no-overwrite is also on, a full capture register is frozen until rd_cap is pulsed.
- R10: The pin passes two synchronizer flops and one detection register. The captured value is the counter sampled on the fourth rising clock edge after the pin changes.
- R11: After reset, cap_val, hold_val and flag_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous capture pin |
| cnt_in | input | CW (16) | Free-running timebase value |
| edge_sel | input | 2 | Edge select (00 off, 01 rise, 10 fall, 11 both) |
| buf_en | input | 1 | Buffered (two-register) mode |
| nowr_en | input | 1 | No-overwrite protection |
| rd_cap | input | 1 | Read strobe for the capture register |
| rd_hold | input | 1 | Read strobe for the holding register |
| flag_clr | input | 1 | Write-1-to-clear strobe for the flag |
| cap_val | output | CW (16) | Capture register |
| hold_val | output | CW (16) | Holding register |
| flag_out | output | 1 | Capture flag |

## Verification
Any error in the empty/full/freeze state stays invisible until the next qualified pin transition. It then shows four clocks later as one of three symptoms: a flag that rises on a priming edge, a holding register that fails to shift, or a timestamp that changes while it should be frozen. The checks therefore put a pin transition right after each state-changing operation (reads, disable, re-enable, flag clear), so that every hidden state is exposed at the ports within one event. The exact counter value pins down the four-edge latency, because the counter advances on every clock.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    ESEL_OFF  = 2'b00,
    ESEL_RISE = 2'b01,
    ESEL_FALL = 2'b10,
    ESEL_BOTH = 2'b11
  } esel_e;

  // Qualified transition for a given select, previous and current level.
  function automatic logic edge_hit(input logic [1:0] sel, input logic prev,
                                    input logic cur);
    logic rise, fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case (sel)
      ESEL_RISE: edge_hit = rise;
      ESEL_FALL: edge_hit = fall;
      ESEL_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/icap_edge_det.sv
module icap_edge_det
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [1:0] edge_sel,
  output logic       edge_act
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   det;
  logic                   edge_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign det = edge_hit(edge_sel, prev_q, sync_q[LAST]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= sync_q[LAST];
      edge_q <= det;
    end
  end

  assign edge_act = edge_q;

  // R1: a registered edge was qualified by a live select.
  a_r1_edge_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q |-> ($past(edge_sel) != ESEL_OFF));

endmodule

// File: rtl/icap_regs.sv
module icap_regs
  import icap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_act,
  input  logic [CW-1:0] cnt_in,
  input  logic [1:0]    edge_sel,
  input  logic          buf_en,
  input  logic          nowr_en,
  input  logic          rd_cap,
  input  logic          rd_hold,
  output logic [CW-1:0] cap_q,
  output logic [CW-1:0] hold_q,
  output logic          take_first,
  output logic          take_shift,
  output logic          take_plain
);
  logic cap_full_q, hold_full_q, pair_lock_q;
  logic act, locked, take, both_empty;
  logic cap_full_rd, hold_full_rd;

  assign act          = edge_act && (edge_sel != ESEL_OFF);
  assign both_empty   = !cap_full_q && !hold_full_q;
  assign locked       = nowr_en && (buf_en ? pair_lock_q : cap_full_q);
  assign take         = act && !locked;
  assign take_first   = take && buf_en && both_empty;
  assign take_shift   = take && buf_en && !both_empty;
  assign take_plain   = take && !buf_en;
  assign cap_full_rd  = cap_full_q && !rd_cap;
  assign hold_full_rd = hold_full_q && !rd_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      hold_q <= '0;
    end else if (take_shift) begin
      hold_q <= cap_q;
      cap_q  <= cnt_in;
    end else if (take_first || take_plain) begin
      cap_q  <= cnt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_full_q  <= 1'b0;
      hold_full_q <= 1'b0;
      pair_lock_q <= 1'b0;
    end else if (edge_sel == ESEL_OFF) begin
      cap_full_q  <= 1'b0;
      hold_full_q <= 1'b0;
      pair_lock_q <= 1'b0;
    end else if (take_shift) begin
      cap_full_q  <= 1'b1;
      hold_full_q <= 1'b1;
      pair_lock_q <= 1'b1;
    end else begin
      cap_full_q  <= cap_full_rd || take_first || take_plain;
      hold_full_q <= hold_full_rd;
      if (!cap_full_rd && !hold_full_rd) pair_lock_q <= 1'b0;
    end
  end

  // R2: disabling leaves both registers marked empty.
  a_r2_off_marks_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == ESEL_OFF) |=> (!cap_full_q && !hold_full_q));

  // R3: a priming edge loads the counter and keeps the holding register.
  a_r3_first_loads: assert property (@(posedge clk) disable iff (!rst_n)
    take_first |=> ((cap_q == $past(cnt_in)) && $stable(hold_q)));

  // R4: a second edge shifts the older stamp behind the new one.
  a_r4_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    take_shift |=> ((hold_q == $past(cap_q)) && (cap_q == $past(cnt_in))));

  // R5: frozen registers ignore edges.
  a_r5_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (act && locked) |=> ($stable(cap_q) && $stable(hold_q)));

  // R9: unbuffered capture never touches the holding register.
  a_r9_plain_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    take_plain |=> $stable(hold_q));

endmodule

// File: rtl/icap_flag.sv
module icap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  // R7: setting beats a coincident clear.
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> flag_q);

  // R7: a lone clear drops the flag.
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !flag_q);

endmodule

// File: rtl/icap_buffered_chan.sv
module icap_buffered_chan
  import icap_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [1:0]    edge_sel,
  input  logic          buf_en,
  input  logic          nowr_en,
  input  logic          rd_cap,
  input  logic          rd_hold,
  input  logic          flag_clr,
  output logic [CW-1:0] cap_val,
  output logic [CW-1:0] hold_val,
  output logic          flag_out
);
  logic edge_act;
  logic take_first, take_shift, take_plain;
  logic flag_set;

  icap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .edge_sel (edge_sel),
    .edge_act (edge_act)
  );

  icap_regs #(.CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_act   (edge_act),
    .cnt_in     (cnt_in),
    .edge_sel   (edge_sel),
    .buf_en     (buf_en),
    .nowr_en    (nowr_en),
    .rd_cap     (rd_cap),
    .rd_hold    (rd_hold),
    .cap_q      (cap_val),
    .hold_q     (hold_val),
    .take_first (take_first),
    .take_shift (take_shift),
    .take_plain (take_plain)
  );

  assign flag_set = take_shift || take_plain;

  icap_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (flag_set),
    .clr_req (flag_clr),
    .flag_q  (flag_out)
  );

  // R3: a priming edge alone never raises the flag.
  a_r3_first_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (take_first && !flag_out) |=> !flag_out);

  // R4: a shift always leaves the flag raised.
  a_r4_shift_flags: assert property (@(posedge clk) disable iff (!rst_n)
    take_shift |=> flag_out);

endmodule

// File: tb/test_icap_buffered_chan.sv
module test_icap_buffered_chan;
  localparam int CW = 16;

  typedef struct {
    logic [CW-1:0] cap;
    logic [CW-1:0] hold;
    logic          flag;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin_in = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic [1:0]    edge_sel = 2'b00;
  logic          buf_en = 1'b0, nowr_en = 1'b0;
  logic          rd_cap = 1'b0, rd_hold = 1'b0, flag_clr = 1'b0;
  logic [CW-1:0] cap_val, hold_val;
  logic          flag_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t sb_q[$];
  event chk_ev;

  // bench model of the channel
  logic [CW-1:0] m_cap = '0, m_hold = '0;
  logic          m_flag = 1'b0, m_cf = 1'b0, m_hf = 1'b0, m_lock = 1'b0;

  always #10 clk = ~clk;
  always @(negedge clk) cnt_in <= cnt_in + 1'b1;

  icap_buffered_chan #(.CW(CW)) i_icap_buffered_chan (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cnt_in(cnt_in),
    .edge_sel(edge_sel), .buf_en(buf_en), .nowr_en(nowr_en),
    .rd_cap(rd_cap), .rd_hold(rd_hold), .flag_clr(flag_clr),
    .cap_val(cap_val), .hold_val(hold_val), .flag_out(flag_out)
  );

  // monitor
  always begin
    @(chk_ev);
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (cap_val !== e.cap || hold_val !== e.hold || flag_out !== e.flag) begin
        n_bad++;
        $display("FAIL %s: actual cap=%h hold=%h flag=%b expected cap=%h hold=%h flag=%b",
                 e.req, cap_val, hold_val, flag_out, e.cap, e.hold, e.flag);
      end
    end
  end

  task automatic push_check(input string req);
    exp_t e;
    e.cap = m_cap; e.hold = m_hold; e.flag = m_flag; e.req = req;
    sb_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  // Model one edge per the requirements; stamp = counter at 4th rising edge.
  task automatic model_edge(input logic old_lv, input logic new_lv,
                            input logic [CW-1:0] stamp, output logic setf);
    logic valid, lk;
    setf = 1'b0;
    valid = (edge_sel == 2'b01 && !old_lv && new_lv) ||
            (edge_sel == 2'b10 && old_lv && !new_lv) ||
            (edge_sel == 2'b11 && old_lv != new_lv);
    if (!valid) return;
    lk = nowr_en && (buf_en ? m_lock : m_cf);
    if (lk) return;
    if (!buf_en) begin
      m_cap = stamp; m_cf = 1'b1; setf = 1'b1;
    end else if (!m_cf && !m_hf) begin
      m_cap = stamp; m_cf = 1'b1;
    end else begin
      m_hold = m_cap; m_cap = stamp; m_cf = 1'b1; m_hf = 1'b1; m_lock = 1'b1;
      setf = 1'b1;
    end
  endtask

  task automatic pin_event(input logic lv, input bit clr_same, input string req);
    logic [CW-1:0] c;
    logic old_lv, setf;
    @(negedge clk); #1;
    c = cnt_in;
    old_lv = pin_in;
    pin_in = lv;
    model_edge(old_lv, lv, c + 16'd3, setf);
    if (setf) m_flag = 1'b1;
    else if (clr_same) m_flag = 1'b0;
    if (clr_same) begin
      repeat (3) @(negedge clk);
      #1 flag_clr = 1'b1;
      @(negedge clk); #1 flag_clr = 1'b0;
    end
    repeat (5) @(negedge clk);
    #2;
    push_check(req);
  endtask

  task automatic pulse(input int which);
    @(negedge clk); #1;
    case (which)
      0: rd_cap = 1'b1;
      1: rd_hold = 1'b1;
      default: flag_clr = 1'b1;
    endcase
    @(negedge clk); #1;
    rd_cap = 1'b0; rd_hold = 1'b0; flag_clr = 1'b0;
    case (which)
      0: m_cf = 1'b0;
      1: m_hf = 1'b0;
      default: m_flag = 1'b0;
    endcase
    if (!m_cf && !m_hf) m_lock = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] sel, input logic be, input logic nw);
    @(negedge clk); #1;
    edge_sel = sel; buf_en = be; nowr_en = nw;
    if (sel == 2'b00) begin m_cf = 1'b0; m_hf = 1'b0; m_lock = 1'b0; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    push_check("R11 reset state");

    // rising select, buffered, no protection
    set_cfg(2'b01, 1'b1, 1'b0);
    pin_event(1'b1, 0, "R3 R10 first rising edge primes");
    pin_event(1'b0, 0, "R1 falling edge ignored on rise select");
    pin_event(1'b1, 0, "R4 second edge shifts and flags");
    pulse(2);
    push_check("R7 flag clear");
    pin_event(1'b0, 0, "R1 falling ignored again");
    pin_event(1'b1, 0, "R4 shift with both full, no protection");

    // disable then re-arm with falling select
    set_cfg(2'b00, 1'b1, 1'b0);
    pulse(2);
    pin_event(1'b0, 0, "R2 off: transition ignored");
    set_cfg(2'b10, 1'b1, 1'b0);
    pin_event(1'b1, 0, "R1 rising ignored on fall select");
    pin_event(1'b0, 0, "R2 R3 first edge after re-enable no flag");
    set_cfg(2'b11, 1'b1, 1'b0);
    pin_event(1'b1, 0, "R1 both select shifts on rise");

    // protection
    set_cfg(2'b11, 1'b1, 1'b1);
    pin_event(1'b0, 0, "R5 frozen when both full");
    pulse(0);
    pin_event(1'b1, 0, "R5 R6 still frozen after one read");
    pulse(2);
    pin_event(1'b0, 0, "R6 edge between service steps ignored");
    pulse(1);
    pin_event(1'b1, 0, "R6 R8 after both reads first edge no flag");
    pin_event(1'b0, 0, "R6 next edge flags again");
    pin_event(1'b1, 1, "R5 R7 locked edge with clear: flag drops");
    pulse(0); pulse(1);
    pin_event(1'b0, 0, "R8 reads empty: priming edge");
    pin_event(1'b1, 1, "R7 set wins over coincident clear");

    // unbuffered
    set_cfg(2'b00, 1'b0, 1'b0);
    pulse(2);
    set_cfg(2'b11, 1'b0, 1'b0);
    pin_event(1'b0, 0, "R9 plain capture flags");
    pulse(2);
    pin_event(1'b1, 0, "R9 plain capture overwrites");
    set_cfg(2'b11, 1'b0, 1'b1);
    pulse(2);
    pin_event(1'b0, 0, "R9 plain frozen while capture full");
    pulse(0);
    pin_event(1'b1, 0, "R9 plain capture after read");

    #5;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule